// File: doc/BRIEF.md
# Programmable-Resolution Message Time Stamp Counter

This block keeps a 16-bit running count that the message-handling logic of a serial data bus terminal samples to stamp each message it handles, whether the terminal acts as bus controller, remote terminal or monitor. One copy is placed per bus port. A prescaler divides the system clock so that one count stands for 2, 4, 8, 16, 32 or 64 microseconds. A 3-bit select picks the resolution. The two spare select codes hold the count still.

The host can load any value into the count, and the next increment after a load comes one full resolution period later. For self-test, a single-cycle step pulse adds one to the count regardless of the prescaler. When the count wraps from all ones to zero, a sticky wrap flag is raised. It stays up until the host clears it.

Top module: `ts_stamp_counter`

## Requirements
- R1: Synchronous reset, active high, drives the count to 0x0000 and the wrap flag to 0. The first prescaled increment after reset is released arrives one full period later.
- R2: For select codes 0 to 5, the count rises by one every CYC_PER_US * 2^(code+1) clock cycles. Code 0 gives 2 us, 1 gives 4 us, 2 gives 8 us, 3 gives 16 us, 4 gives 32 us and 5 gives 64 us.
- R3: Select codes 6 and 7 stop the prescaler. With no load and no step, the count holds its value.
- R4: A load puts the data word into the count at the next clock edge and restarts the prescaler phase, so the next increment follows a full period later. A load takes priority over a step or prescaler increment in the same cycle.
- R5: A step pulse adds exactly one to the count at the next edge. This holds at any select code, including the stop codes.
- R6: When a step and a prescaler increment fall on the same edge, the count rises by two.
- R7: The count wraps from 0xFFFF to 0x0000. Any increment that carries out of bit 15 sets the wrap flag, and the flag then stays set.
- R8: A clear pulse lowers the wrap flag. If a wrap happens on the same edge as a clear, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| res_sel | input | 3 | Resolution select code (0-5 run, 6-7 stop) |
| load_en | input | 1 | Load the count from load_val |
| load_val | input | 16 | Value to load |
| step | input | 1 | Self-test single increment |
| wrap_clr | input | 1 | Clear the sticky wrap flag |
| stamp | output | 16 | Current count for message stamping |
| wrapped | output | 1 | Sticky wrap flag |

## Verification
The bench runs each running select code for three full periods right after a load, comparing the count on every cycle against the floor of elapsed cycles divided by the period. This catches wrong dividers, off-by-one phases and a missing phase restart. The stop codes are held for many cycles while a step is injected, which separates the prescaler from the self-test path. Collisions are forced deliberately: a load against a step, a step against a prescaler increment, and a wrap against a clear. These cases expose any wrong priority in the next-state logic.

// File: rtl/ts_stamp_pkg.sv
package ts_stamp_pkg;

    typedef enum logic [2:0] {
        RES_2US  = 3'd0,
        RES_4US  = 3'd1,
        RES_8US  = 3'd2,
        RES_16US = 3'd3,
        RES_32US = 3'd4,
        RES_64US = 3'd5,
        RES_HALT_A = 3'd6,
        RES_HALT_B = 3'd7
    } res_code_e;

    // Decoded resolution: run enable and log2 of the microsecond multiple
    typedef struct packed {
        logic       run;
        logic [2:0] shift;
    } res_cfg_t;

    // Increment request toward the counter
    typedef struct packed {
        logic tick;
        logic step;
    } inc_req_t;

    function automatic res_cfg_t decode_res(input logic [2:0] code);
        res_cfg_t c;
        c.run   = (code <= 3'(RES_64US));
        c.shift = c.run ? 3'(code + 3'd1) : 3'd0;
        return c;
    endfunction

    function automatic logic [1:0] inc_amount(input inc_req_t r);
        return {1'b0, r.tick} + {1'b0, r.step};
    endfunction

endpackage

// File: rtl/ts_res_decode.sv
module ts_res_decode
    import ts_stamp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic [2:0] res_sel,
    output res_cfg_t cfg
);
    assign cfg = decode_res(res_sel);

    // R3: halt codes never enable the prescaler
    p_halt_codes_r3: assert property (@(posedge clk) disable iff (rst)
        (res_sel >= 3'd6) |-> !cfg.run);

    // R2: running codes map to a shift of code+1
    p_shift_map_r2: assert property (@(posedge clk) disable iff (rst)
        (res_sel < 3'd6) |-> (cfg.run && (cfg.shift == res_sel + 3'd1)));
endmodule

// File: rtl/ts_prescaler.sv
module ts_prescaler
    import ts_stamp_pkg::*;
#(
    parameter int CYC_PER_US = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  res_cfg_t cfg,
    input  logic     restart,
    output logic     tick
);
    localparam int PMAX = CYC_PER_US * 64;
    localparam int PW   = $clog2(PMAX + 1);

    logic [PW-1:0] phase;
    logic [PW-1:0] period;

    always_comb begin
        period = PW'(CYC_PER_US) << cfg.shift;
    end

    assign tick = cfg.run && !restart && (phase >= period - PW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (cfg.run) begin
            if (tick) phase <= '0;
            else      phase <= phase + PW'(1);
        end
    end

    // R2: ticks are never back to back (shortest period is two cycles)
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R4: after a restart the next cycle can not tick
    p_restart_phase_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick);

    // R3: stopped prescaler keeps its phase
    p_frozen_phase_r3: assert property (@(posedge clk) disable iff (rst)
        (!cfg.run && !restart) |=> $stable(phase));
endmodule

// File: rtl/ts_count_core.sv
module ts_count_core
    import ts_stamp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  inc_req_t         req,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [1:0]     amt;
    logic [CNT_W:0] sum;
    logic           carry;

    always_comb begin
        amt   = inc_amount(req);
        sum   = {1'b0, count} + (CNT_W+1)'(amt);
        carry = sum[CNT_W] && !load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            wrap  <= 1'b0;
        end else begin
            if (load) count <= load_val;
            else      count <= sum[CNT_W-1:0];
            if (carry)    wrap <= 1'b1;
            else if (clr) wrap <= 1'b0;
        end
    end

    // R4: load lands on the next edge
    p_load_value_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)));

    // R5: lone step adds exactly one
    p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
        (req.step && !req.tick && !load) |=> (count == $past(count) + CNT_W'(1)));

    // R6: coincident step and tick add two
    p_double_inc_r6: assert property (@(posedge clk) disable iff (rst)
        (req.step && req.tick && !load) |=> (count == $past(count) + CNT_W'(2)));

    // R7: flag is sticky without a clear
    p_wrap_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (wrap && !clr) |=> wrap);

    // R7: increment from all ones raises the flag
    p_wrap_set_r7: assert property (@(posedge clk) disable iff (rst)
        ((count == {CNT_W{1'b1}}) && (req.step || req.tick) && !load) |=> wrap);

    // R8: clear without a wrap lowers the flag
    p_wrap_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && !(req.step || req.tick)) |=> !wrap);
endmodule

// File: rtl/ts_stamp_counter.sv
module ts_stamp_counter
    import ts_stamp_pkg::*;
#(
    parameter int CYC_PER_US = 16,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       res_sel,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic             wrap_clr,
    output logic [CNT_W-1:0] stamp,
    output logic             wrapped
);
    res_cfg_t cfg;
    inc_req_t req;
    logic     tick;

    ts_res_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .res_sel (res_sel),
        .cfg     (cfg)
    );

    ts_prescaler #(.CYC_PER_US(CYC_PER_US)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .restart (load_en),
        .tick    (tick)
    );

    assign req.tick = tick;
    assign req.step = step;

    ts_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .load     (load_en),
        .load_val (load_val),
        .clr      (wrap_clr),
        .count    (stamp),
        .wrap     (wrapped)
    );

    // R3: halt codes freeze the count at the ports
    p_halt_holds_r3: assert property (@(posedge clk) disable iff (rst)
        ((res_sel >= 3'd6) && !load_en && !step) |=> $stable(stamp));

    // R1: reset state seen at the ports
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (stamp == '0 && !wrapped));
endmodule

// File: tb/ts_stamp_counter_tb.sv
module ts_stamp_counter_tb;
    localparam int CPU = 1;

    logic        clk = 0;
    logic        rst = 1;
    logic [2:0]  res_sel = 3'd0;
    logic        load_en = 0;
    logic [15:0] load_val = '0;
    logic        step = 0;
    logic        wrap_clr = 0;
    logic [15:0] stamp;
    logic        wrapped;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ts_stamp_counter #(.CYC_PER_US(CPU), .CNT_W(16)) u_dut (
        .clk(clk), .rst(rst), .res_sel(res_sel), .load_en(load_en),
        .load_val(load_val), .step(step), .wrap_clr(wrap_clr),
        .stamp(stamp), .wrapped(wrapped)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [15:0] v);
        @(negedge clk);
        load_en = 1; load_val = v;
        @(negedge clk);
        load_en = 0;
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 count", stamp, 0);
        check("R1 flag", wrapped, 0);
        @(negedge clk);
        check("R1 first period", stamp, 0);
        @(negedge clk);
        check("R1 first period", stamp, 1);

        // R2 sweep over every running code
        for (int code = 0; code < 6; code++) begin
            int per;
            per = CPU << (code + 1);
            res_sel = 3'(code);
            do_load(16'h0000);
            for (int e = 1; e <= 3 * per; e++) begin
                @(negedge clk);
                check("R2 period", stamp, e / per);
            end
        end

        // R3 halt codes
        for (int code = 6; code < 8; code++) begin
            res_sel = 3'(code);
            do_load(16'h0ABC);
            repeat (150) @(negedge clk);
            check("R3 halted", stamp, 16'h0ABC);
        end

        // R5 step while halted
        res_sel = 3'd6;
        do_load(16'h0100);
        step = 1;
        @(negedge clk);
        step = 0;
        check("R5 step", stamp, 16'h0101);
        repeat (20) @(negedge clk);
        check("R5 step single", stamp, 16'h0101);

        // R4 load priority and phase restart
        res_sel = 3'd0;
        do_load(16'h0005);
        @(negedge clk);
        load_en = 1; load_val = 16'h0200; step = 1;
        @(negedge clk);
        load_en = 0; step = 0;
        check("R4 priority", stamp, 16'h0200);
        @(negedge clk);
        check("R4 phase", stamp, 16'h0200);
        @(negedge clk);
        check("R4 phase", stamp, 16'h0201);

        // R6 step on a tick edge
        do_load(16'h0010);
        @(negedge clk);
        step = 1;
        @(negedge clk);
        step = 0;
        check("R6 double", stamp, 16'h0012);

        // R7 wrap by step
        res_sel = 3'd7;
        do_load(16'hFFFE);
        step = 1;
        @(negedge clk);
        check("R7 near", stamp, 16'hFFFF);
        check("R7 no flag", wrapped, 0);
        @(negedge clk);
        step = 0;
        check("R7 wrap", stamp, 0);
        check("R7 flag", wrapped, 1);
        repeat (5) @(negedge clk);
        check("R7 sticky", wrapped, 1);

        // R8 clear then set-wins
        wrap_clr = 1;
        @(negedge clk);
        wrap_clr = 0;
        check("R8 clear", wrapped, 0);
        do_load(16'hFFFF);
        check("R8 load no flag", wrapped, 0);
        step = 1; wrap_clr = 1;
        @(negedge clk);
        step = 0; wrap_clr = 0;
        check("R8 set wins", wrapped, 1);
        check("R8 count", stamp, 0);

        // R7 wrap by prescaler tick
        wrap_clr = 1;
        @(negedge clk);
        wrap_clr = 0;
        res_sel = 3'd0;
        do_load(16'hFFFF);
        repeat (2) @(negedge clk);
        check("R7 tick wrap", stamp, 0);
        check("R7 tick flag", wrapped, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule